// File: doc/BRIEF.md
# Partial-Reseed Scan Pattern Source

This block turns a slow serial stream of tester bits into full scan-chain loads. A linear feedback shift register of width R produces each scan bit. For the first pattern after reset, the tester supplies a complete R-bit seed. No scan data leaves the block while that seed loads. The register then clocks out exactly L scan bits. Every later pattern needs only N tester bits, with N smaller than R. Those bits are XORed into the feedback path during the first N scan clocks of the pattern. After that the register free-runs until the chain holds L bits.

A pattern begins with a one-cycle `start` pulse while the unit is idle. During a seed phase, a cycle with `tst_valid` low is a stall: the register and the scan stream both hold. Outside the seed phases the tester lines have no effect. The output stream is fully determined by the seed and the injected bits, so the tester can precompute every expected pattern.

Top module: `partial_reseed_unit`

## Requirements
- R1: During and after synchronous reset, `scan_shift`, `scan_out` and `pattern_done` are 0 and the unit is idle.
- R2: The first `start` after reset begins a full seed. Each of the next R cycles with `tst_valid` high shifts `tst_bit` directly into bit 0 of the register while the other bits move one place up (bit i to bit i+1). No scan bit is emitted during this phase.
- R3: After a full seed, the unit emits L scan bits on L consecutive cycles. Each bit is the feedback value, the XOR of the register bits selected by the tap mask (default 16'hB400, bits 15, 13, 12 and 10). That bit also shifts into bit 0. It appears on `scan_out` with `scan_shift` high in the cycle after the clock edge that produced it.
- R4: Every `start` after the first, up to the next reset, begins a partial pattern of exactly L scan bits. For the first N of those bits, the new bit is the feedback XOR the tester bit. The remaining L-N bits are plain feedback.
- R5: In either seed phase, a cycle with `tst_valid` low leaves the register unchanged and emits no scan bit.
- R6: `tst_bit` and `tst_valid` have no effect while the unit is idle or free-running.
- R7: `pattern_done` is high for exactly one cycle: the cycle right after the one in which the L-th scan bit of the pattern was presented.
- R8: `start` has no effect unless the unit is idle.
- R9: A reset in mid-pattern aborts it. The next pattern again takes a full R-bit seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a pattern |
| tst_bit | input | 1 | Serial seed bit from the tester |
| tst_valid | input | 1 | Qualifies `tst_bit` in a seed phase |
| scan_out | output | 1 | Serial data toward the scan chain |
| scan_shift | output | 1 | High in each cycle that carries a scan bit |
| pattern_done | output | 1 | One-cycle pulse after the last scan bit |

## Verification
The bench uses the defaults: R = 16, N = 8, L = 32 and tap mask 16'hB400. With these values a full-seed pattern, several partial patterns with random stalls, and a reset in mid-pattern all fit in a few hundred cycles. Since N is half of R, an error in the injection window length or in choosing between full and partial seeding changes the scan stream within a few bits. A 32-bit chain is twice the register width, so the stream is checked well past the point where every seed bit has left the register. This exposes wrong tap positions or a wrong shift direction.

// File: rtl/pr_pkg.sv
package pr_pkg;

    localparam int unsigned PR_LFSR_W  = 16;
    localparam int unsigned PR_PART_N  = 8;
    localparam int unsigned PR_CHAIN_L = 32;
    localparam logic [PR_LFSR_W-1:0] PR_TAPS = 16'hB400;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_FULL    = 3'd1,
        PH_PARTIAL = 3'd2,
        PH_FREE    = 3'd3,
        PH_DONE    = 3'd4
    } phase_e;

    // per-cycle command from the controller to the datapath
    typedef struct packed {
        logic adv;   // register advances this cycle
        logic load;  // direct seed load (feedback ignored)
        logic inj;   // XOR tester bit into feedback
        logic emit;  // the new bit is a scan bit
    } step_cmd_t;

    function automatic int unsigned pr_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pr_lfsr.sv
module pr_lfsr
    import pr_pkg::*;
#(
    parameter int unsigned W = PR_LFSR_W,
    parameter logic [W-1:0] TAPS = PR_TAPS[W-1:0]
) (
    input  logic         clk,
    input  logic         rst,
    input  step_cmd_t    cmd,
    input  logic         tbit,
    output logic         new_bit,
    output logic [W-1:0] state
);

    logic [W-1:0] q;
    logic         fb;

    always_comb begin
        fb = ^(q & TAPS);
        if (cmd.load)
            new_bit = tbit;
        else
            new_bit = fb ^ (cmd.inj & tbit);
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (cmd.adv)
            q <= {q[W-2:0], new_bit};
    end

    assign state = q;

endmodule

// File: rtl/pr_ctrl.sv
module pr_ctrl
    import pr_pkg::*;
#(
    parameter int unsigned R = PR_LFSR_W,
    parameter int unsigned N = PR_PART_N,
    parameter int unsigned L = PR_CHAIN_L,
    localparam int unsigned CNT_W = $clog2(pr_max(R, L) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tvalid,
    output step_cmd_t        cmd,
    output phase_e           phase,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] R_LAST = CNT_W'(R - 1);
    localparam logic [CNT_W-1:0] N_LAST = CNT_W'(N - 1);
    localparam logic [CNT_W-1:0] N_CNT  = CNT_W'(N);
    localparam logic [CNT_W-1:0] L_LAST = CNT_W'(L - 1);

    phase_e           ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             seeded_q, seeded_d;

    always_comb begin
        ph_d     = ph_q;
        cnt_d    = cnt_q;
        seeded_d = seeded_q;
        cmd      = '0;
        unique case (ph_q)
            PH_IDLE: begin
                if (start) begin
                    cnt_d = '0;
                    ph_d  = seeded_q ? PH_PARTIAL : PH_FULL;
                end
            end
            PH_FULL: begin
                cmd.adv  = tvalid;
                cmd.load = 1'b1;
                if (tvalid) begin
                    if (cnt_q == R_LAST) begin
                        cnt_d    = '0;
                        seeded_d = 1'b1;
                        ph_d     = PH_FREE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PH_PARTIAL: begin
                cmd.adv  = tvalid;
                cmd.inj  = 1'b1;
                cmd.emit = 1'b1;
                if (tvalid) begin
                    if (cnt_q == N_LAST) begin
                        cnt_d = N_CNT;
                        ph_d  = (N_CNT == CNT_W'(L)) ? PH_DONE : PH_FREE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PH_FREE: begin
                cmd.adv  = 1'b1;
                cmd.emit = 1'b1;
                if (cnt_q == L_LAST) begin
                    cnt_d = '0;
                    ph_d  = PH_DONE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_DONE: begin
                ph_d = PH_IDLE;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            cnt_q    <= '0;
            seeded_q <= 1'b0;
        end else begin
            ph_q     <= ph_d;
            cnt_q    <= cnt_d;
            seeded_q <= seeded_d;
        end
    end

    assign phase = ph_q;
    assign count = cnt_q;

endmodule

// File: rtl/pr_scan_port.sv
module pr_scan_port
    import pr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  step_cmd_t cmd,
    input  phase_e    phase,
    input  logic      new_bit,
    output logic      sdata,
    output logic      sshift,
    output logic      done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sdata  <= 1'b0;
            sshift <= 1'b0;
            done   <= 1'b0;
        end else begin
            sshift <= cmd.adv & cmd.emit;
            if (cmd.adv && cmd.emit)
                sdata <= new_bit;
            done <= (phase == PH_DONE);
        end
    end

endmodule

// File: rtl/partial_reseed_unit.sv
module partial_reseed_unit
    import pr_pkg::*;
#(
    parameter int unsigned R = PR_LFSR_W,
    parameter int unsigned N = PR_PART_N,
    parameter int unsigned L = PR_CHAIN_L,
    parameter logic [R-1:0] TAPS = PR_TAPS[R-1:0]
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tst_bit,
    input  logic tst_valid,
    output logic scan_out,
    output logic scan_shift,
    output logic pattern_done
);

    localparam int unsigned CNT_W = $clog2(pr_max(R, L) + 1);

    step_cmd_t        cmd;
    phase_e           phase;
    logic [CNT_W-1:0] count;
    logic             new_bit;
    logic [R-1:0]     lfsr_state;

    pr_ctrl #(.R(R), .N(N), .L(L)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .tvalid (tst_valid),
        .cmd    (cmd),
        .phase  (phase),
        .count  (count)
    );

    pr_lfsr #(.W(R), .TAPS(TAPS)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .tbit    (tst_bit),
        .new_bit (new_bit),
        .state   (lfsr_state)
    );

    pr_scan_port u_port (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .phase   (phase),
        .new_bit (new_bit),
        .sdata   (scan_out),
        .sshift  (scan_shift),
        .done    (pattern_done)
    );

endmodule

// File: rtl/pr_checker.sv
module pr_checker
    import pr_pkg::*;
#(
    parameter int unsigned R = PR_LFSR_W,
    parameter int unsigned L = PR_CHAIN_L,
    parameter int unsigned CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             tst_valid,
    input logic             scan_shift,
    input logic             pattern_done,
    input phase_e           phase,
    input logic [CNT_W-1:0] count,
    input logic [R-1:0]     lfsr_state
);

    // R7: done lasts a single cycle
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        pattern_done |=> !pattern_done);

    // R7: done directly follows a scan bit
    assert_done_after_bit_R7: assert property (@(posedge clk) disable iff (rst)
        pattern_done |-> $past(scan_shift));

    // R2: a full-seed cycle produces no scan bit
    assert_full_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FULL) |=> !scan_shift);

    // R5: stalled seed phase holds the register and emits nothing
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_FULL || phase == PH_PARTIAL) && !tst_valid)
        |=> ($stable(lfsr_state) && !scan_shift));

    // R6: idle register does not move
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> $stable(lfsr_state));

    // R8: start while free-running does not restart seeding
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FREE && start) |=> (phase != PH_FULL && phase != PH_PARTIAL));

    // R3: scan count never passes the chain length
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(pr_max(R, L)));

endmodule

bind partial_reseed_unit pr_checker #(.R(R), .L(L), .CNT_W(CNT_W)) u_pr_checker (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .tst_valid    (tst_valid),
    .scan_shift   (scan_shift),
    .pattern_done (pattern_done),
    .phase        (phase),
    .count        (count),
    .lfsr_state   (lfsr_state)
);

// File: tb/tb_partial_reseed_unit.sv
module tb_partial_reseed_unit;

    localparam int R = 16;
    localparam int N = 8;
    localparam int L = 32;
    localparam logic [15:0] TAPS = 16'hB400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic tst_bit = 1'b0;
    logic tst_valid = 1'b0;
    logic scan_out, scan_shift, pattern_done;

    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [15:0] model;
    logic        got_bits [64];
    logic        exp_bits [64];
    int          got_n = 0;
    int          done_n = 0;
    int          done_bad = 0;
    logic        prev_shift = 1'b0;
    logic        mon_on = 1'b0;
    int unsigned rnd_seed;

    partial_reseed_unit dut (
        .clk(clk), .rst(rst), .start(start), .tst_bit(tst_bit),
        .tst_valid(tst_valid), .scan_out(scan_out),
        .scan_shift(scan_shift), .pattern_done(pattern_done)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // monitor: sample between edges
    always @(negedge clk) begin
        if (mon_on) begin
            if (pattern_done) begin
                done_n++;
                if (!prev_shift || got_n != L) done_bad++;
            end
            if (scan_shift && got_n < 64) begin
                got_bits[got_n] = scan_out;
                got_n++;
            end
        end
        prev_shift = scan_shift;
    end

    function automatic logic fb_of(input logic [15:0] s);
        return ^(s & TAPS);
    endfunction

    task automatic run_pattern(input bit full, input logic [15:0] seed,
                               input int stall_pct, input bit poke_start);
        int need;
        int k;
        int w;
        logic nb;
        // expected stream
        if (full) begin
            for (int i = 0; i < R; i++) model = {model[14:0], seed[R-1-i]};
            for (int i = 0; i < L; i++) begin
                nb = fb_of(model);
                model = {model[14:0], nb};
                exp_bits[i] = nb;
            end
        end else begin
            for (int i = 0; i < L; i++) begin
                nb = fb_of(model);
                if (i < N) nb = nb ^ seed[N-1-i];
                model = {model[14:0], nb};
                exp_bits[i] = nb;
            end
        end
        need = full ? R : N;
        @(negedge clk);
        got_n = 0; done_n = 0; done_bad = 0; mon_on = 1'b1;
        start = 1'b1;
        tst_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (k < need) begin
            if (int'($urandom_range(99)) < stall_pct) begin
                tst_valid = 1'b0;
                tst_bit = 1'($urandom_range(1));
            end else begin
                tst_valid = 1'b1;
                tst_bit = full ? seed[R-1-k] : seed[N-1-k];
                k++;
            end
            @(negedge clk);
        end
        // free run: tester noise must be ignored (R6)
        w = 0;
        while (done_n == 0 && w < 400) begin
            tst_valid = 1'($urandom_range(1));
            tst_bit = 1'($urandom_range(1));
            start = (poke_start && w == 3) ? 1'b1 : 1'b0;
            @(negedge clk);
            w++;
        end
        start = 1'b0;
        tst_valid = 1'b0;
        repeat (3) @(negedge clk);
        mon_on = 1'b0;
        check(got_n == L, full ? "R3 scan bit count" : "R4 scan bit count", got_n, L);
        for (int i = 0; i < L; i++) begin
            if (got_bits[i] !== exp_bits[i]) begin
                check(1'b0, full ? "R3 scan bit value" : "R4/R5/R6 scan bit value",
                      int'(got_bits[i]), int'(exp_bits[i]));
                break;
            end
            if (i == L - 1) check(1'b1, "R3/R4 stream", 0, 0);
        end
        check(done_n == 1, "R7 done pulse count", done_n, 1);
        check(done_bad == 0, "R7 done timing", done_bad, 0);
    endtask

    initial begin
        rnd_seed = 32'h5EED;
        void'($urandom(rnd_seed));
        model = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(scan_shift == 1'b0, "R1 scan_shift", int'(scan_shift), 0);
        check(pattern_done == 1'b0, "R1 pattern_done", int'(pattern_done), 0);
        check(scan_out == 1'b0, "R1 scan_out", int'(scan_out), 0);
        rst = 1'b0;
        // R2/R3: first pattern takes a full seed, with stalls (R5)
        run_pattern(1'b1, 16'hACE1, 30, 1'b0);
        // R6: idle tester noise
        repeat (10) begin
            @(negedge clk);
            tst_valid = 1'($urandom_range(1));
            tst_bit = 1'($urandom_range(1));
        end
        tst_valid = 1'b0;
        check(scan_shift == 1'b0, "R6 idle no scan", int'(scan_shift), 0);
        // R4: partial patterns, random seeds and stalls
        for (int p = 0; p < 6; p++)
            run_pattern(1'b0, 16'($urandom_range(16'hFFFF)), 10 * p, p == 2);
        // corner: all-zero partial seed, no stalls
        run_pattern(1'b0, 16'h0000, 0, 1'b0);
        // R8: start poked in free run
        run_pattern(1'b0, 16'h00A5, 20, 1'b1);
        // R9: reset mid-pattern
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tst_valid = 1'b1;
        tst_bit = 1'b1;
        repeat (4) @(negedge clk);
        tst_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(scan_shift == 1'b0 && pattern_done == 1'b0, "R9 reset aborts",
              int'(scan_shift) + int'(pattern_done), 0);
        rst = 1'b0;
        run_pattern(1'b1, 16'h1F2E, 25, 1'b0);
        run_pattern(1'b0, 16'h003C, 15, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule